// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave with Address Pointer Reads

This block is the slave side of a two-wire serial memory. It holds a 256 x 8 array and watches already-sampled clock (SCL) and data (SDA) lines. It picks out START, repeated START and STOP conditions, checks the device select in the control byte and then either takes in a word address (and at most one data byte) or streams bytes out. SDA is driven open-drain style: the single output asks for the line to be pulled low. The surrounding logic ANDs this request with the bus.

One internal pointer serves every read mode. A read with no address phase returns the byte under the pointer. A write transfer that carries only a word address, followed by a repeated START and a read control byte, becomes a random read. While the master acknowledges each data byte, the slave keeps sending the following addresses. Every completed byte access, read or write, leaves the pointer one past the address it used.

Top module: `serial_mem_slave`

## Requirements
- R1: After reset the slave does not pull SDA low, and it stays released while the bus is idle.
- R2: A control byte is accepted, and acknowledged with SDA pulled low in the ninth bit slot, only when its upper seven bits equal the device code 4'b1010 followed by the CHIP_SEL parameter. Bit 0 is the direction, with 1 meaning read. On a mismatch the slave leaves SDA released until the next START, and the pointer keeps its value.
- R3: A write transfer that ends with STOP right after the acknowledged word address loads the pointer with that address. A following current address read returns the byte stored there.
- R4: In a write transfer, the data byte that follows the word address is acknowledged, stored at that address, and leaves the pointer at the address plus one.
- R5: A read control byte with no address phase returns the byte at the pointer, and each such read advances the pointer by one.
- R6: A word-address write followed by a repeated START and a read control byte returns the byte at the new address.
- R7: While the master acknowledges each data byte (SDA low in its ninth slot), the slave sends the byte at the next address. After a not-acknowledge (SDA high), it releases SDA and sends nothing more.
- R8: The pointer is 8 bits wide and wraps from 0xFF to 0x00 during a sequential read.
- R9: Bytes are sent most significant bit first, and the slave changes its SDA drive only while SCL is low.
- R10: A START or STOP in the middle of an address or data byte abandons the transfer. Nothing is written, the pointer keeps its value, and after a START a new control byte is expected.
- R11: During the master's acknowledge slot after each sent byte, the slave does not pull SDA low.
- R12: A second data byte in the same write transfer is not acknowledged and is not stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; every bus sample and every state change is taken on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sampled serial clock line |
| sda_i | input | 1 | Sampled serial data line (the resolved bus value) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it (registered) |

## Verification
The array is first filled with distinct byte patterns at scattered addresses, including both ends of the address range. This makes a byte returned from the wrong address, or with its bits out of order, stand out. The same stored bytes are then read in four ways: by a random read, by a current address read after a read, by a current address read after an address-only write, and by a sequential stream across the 0xFF to 0x00 boundary. These separate a pointer that was loaded wrongly from one that advanced wrongly. Transfers cut short by a START inside an address byte and by a STOP inside a data byte, a wrong chip select, and a two-byte write each show whether the pointer and the array stayed untouched, which is judged by what the next read returns.

// File: rtl/smem_pkg.sv
package smem_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_CTRL, ST_ADDR, ST_WDATA, ST_ACK,
    ST_RDATA, ST_RACK, ST_RNEXT, ST_SKIP
  } smem_state_t;

  typedef enum logic [1:0] {AK_CTRL, AK_ADDR, AK_WDATA} smem_ack_t;
endpackage

// File: rtl/smem_linemon.sv
module smem_linemon (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_hi,
  output logic sda_now,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_seen,
  output logic stop_seen
);
  logic scl_c, scl_p, sda_c, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_c <= 1'b1; scl_p <= 1'b1;
      sda_c <= 1'b1; sda_p <= 1'b1;
    end else begin
      scl_c <= scl_i; scl_p <= scl_c;
      sda_c <= sda_i; sda_p <= sda_c;
    end
  end

  assign scl_hi     = scl_c;
  assign sda_now    = sda_c;
  assign scl_rise   = scl_c & ~scl_p;
  assign scl_fall   = ~scl_c & scl_p;
  assign start_seen = scl_c & scl_p & sda_p & ~sda_c;
  assign stop_seen  = scl_c & scl_p & ~sda_p & sda_c;

  // R10: bus events used by the controller never overlap
  a_r10_events_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({start_seen, stop_seen, scl_rise, scl_fall}));
endmodule

// File: rtl/smem_store.sv
module smem_store #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/smem_ptr.sv
module smem_ptr #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  output logic [AW-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst)       ptr <= '0;
    else if (load) ptr <= load_val;
    else if (step) ptr <= ptr + AW'(1);
  end

  // R8: stepping past the top address lands on zero
  a_r8_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
    (step && !load && ptr == {AW{1'b1}}) |=> (ptr == '0));
endmodule

// File: rtl/serial_mem_slave.sv
module serial_mem_slave #(
  parameter int          AW       = 8,
  parameter logic [3:0]  DEV_CODE = 4'b1010,
  parameter logic [2:0]  CHIP_SEL = 3'd0
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  import smem_pkg::*;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W) + 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [6:0] MY_SEL = {DEV_CODE, CHIP_SEL};

  logic scl_hi, sda_now, scl_rise, scl_fall, start_seen, stop_seen;

  smem_linemon u_mon (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_hi(scl_hi), .sda_now(sda_now), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_seen(start_seen), .stop_seen(stop_seen)
  );

  smem_state_t state;
  smem_ack_t   kind;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] rx, tx, rd_data;
  logic rd_mode, ack_on;
  logic [AW-1:0] ptr;

  logic [BYTE_W-1:0] byte_in;
  logic byte_done, ptr_load, mem_we, ptr_step, bus_evt;

  assign bus_evt   = start_seen | stop_seen;
  assign byte_in   = {rx[BYTE_W-2:0], sda_now};
  assign byte_done = scl_rise && !bus_evt && (bit_cnt == LAST_BIT);
  assign ptr_load  = byte_done && (state == ST_ADDR);
  assign mem_we    = byte_done && (state == ST_WDATA);
  assign ptr_step  = mem_we || (byte_done && state == ST_RDATA);

  smem_ptr #(.AW(AW)) u_ptr (
    .clk(clk), .rst(rst), .load(ptr_load), .load_val(byte_in[AW-1:0]),
    .step(ptr_step), .ptr(ptr)
  );

  smem_store #(.AW(AW), .DW(BYTE_W)) u_store (
    .clk(clk), .we(mem_we), .waddr(ptr), .wdata(byte_in),
    .raddr(ptr), .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      kind    <= AK_CTRL;
      bit_cnt <= '0;
      rx      <= '0;
      tx      <= '0;
      rd_mode <= 1'b0;
      ack_on  <= 1'b0;
      sda_oe  <= 1'b0;
    end else if (stop_seen) begin
      state  <= ST_IDLE;
      ack_on <= 1'b0;
      sda_oe <= 1'b0;
    end else if (start_seen) begin
      state   <= ST_CTRL;
      bit_cnt <= '0;
      ack_on  <= 1'b0;
      sda_oe  <= 1'b0;
    end else begin
      unique case (state)
        ST_CTRL, ST_ADDR, ST_WDATA: begin
          if (scl_rise) begin
            rx      <= byte_in;
            bit_cnt <= bit_cnt + CNT_W'(1);
            if (bit_cnt == LAST_BIT) begin
              if (state == ST_CTRL) begin
                if (byte_in[BYTE_W-1:1] == MY_SEL) begin
                  rd_mode <= byte_in[0];
                  kind    <= AK_CTRL;
                  state   <= ST_ACK;
                end else begin
                  state <= ST_SKIP;
                end
              end else begin
                kind  <= (state == ST_ADDR) ? AK_ADDR : AK_WDATA;
                state <= ST_ACK;
              end
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            if (!ack_on) begin
              ack_on <= 1'b1;
              sda_oe <= 1'b1;
            end else begin
              ack_on  <= 1'b0;
              bit_cnt <= '0;
              unique case (kind)
                AK_CTRL: begin
                  if (rd_mode) begin
                    tx     <= rd_data;
                    sda_oe <= ~rd_data[BYTE_W-1];
                    state  <= ST_RDATA;
                  end else begin
                    sda_oe <= 1'b0;
                    state  <= ST_ADDR;
                  end
                end
                AK_ADDR: begin
                  sda_oe <= 1'b0;
                  state  <= ST_WDATA;
                end
                default: begin
                  sda_oe <= 1'b0;
                  state  <= ST_SKIP;
                end
              endcase
            end
          end
        end
        ST_RDATA: begin
          if (scl_rise) begin
            bit_cnt <= bit_cnt + CNT_W'(1);
            if (bit_cnt == LAST_BIT) state <= ST_RACK;
          end else if (scl_fall) begin
            tx     <= {tx[BYTE_W-2:0], 1'b0};
            sda_oe <= ~tx[BYTE_W-2];
          end
        end
        ST_RACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
          end else if (scl_rise) begin
            state <= sda_now ? ST_SKIP : ST_RNEXT;
          end
        end
        ST_RNEXT: begin
          if (scl_fall) begin
            tx      <= rd_data;
            sda_oe  <= ~rd_data[BYTE_W-1];
            bit_cnt <= '0;
            state   <= ST_RDATA;
          end
        end
        default: ;
      endcase
    end
  end

  // R9: drive changes are launched only from a low SCL sample
  a_r9_drive_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe)) |-> !$past(scl_hi));

  // R2: idle and ignored transfers never pull the line
  a_r2_quiet_when_unselected: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE || state == ST_SKIP) |-> !sda_oe);

  // R11: line is released when the master's acknowledge bit is clocked
  a_r11_release_master_ack: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RACK && scl_rise) |-> !sda_oe);

  // R5: a completed sent byte moves the pointer by exactly one
  a_r5_read_steps_ptr: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RDATA && byte_done) |=> (ptr == $past(ptr) + AW'(1)));

  // R10: a START inside a byte leaves the pointer as it was
  a_r10_abort_keeps_ptr: assert property (@(posedge clk) disable iff (rst)
    (start_seen && (state == ST_CTRL || state == ST_ADDR || state == ST_WDATA))
      |=> $stable(ptr));
endmodule

// File: tb/sim_serial_mem_slave.sv
module sim_serial_mem_slave;
  localparam int CLK_NS = 10;
  localparam int Q      = 4;
  localparam logic [6:0] SEL = {4'b1010, 3'd5};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  wire  sda_line = m_sda & ~sda_oe;

  int n_cmp = 0;
  int n_bad = 0;
  int r9_viol = 0;
  logic [7:0] model [256];
  logic [7:0] mptr;

  always #(CLK_NS/2) clk = ~clk;

  serial_mem_slave #(.AW(8), .DEV_CODE(4'b1010), .CHIP_SEL(3'd5)) u0 (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe)
  );

  // R9 monitor: drive must not change while SCL stays high
  logic scl_prev = 1'b1;
  logic oe_prev  = 1'b0;
  always @(posedge clk) begin
    if (!rst && m_scl && scl_prev && (sda_oe != oe_prev)) r9_viol++;
    scl_prev <= m_scl;
    oe_prev  <= sda_oe;
  end

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q);
    m_sda = 1'b0; wq(Q); m_scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b1; wq(Q);
  endtask

  task automatic put_bit(input logic b);
    m_sda = b; wq(Q); m_scl = 1'b1; wq(2*Q); m_scl = 1'b0; wq(Q);
  endtask

  task automatic get_bit(output logic b);
    m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q);
    b = sda_line; wq(Q); m_scl = 1'b0; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic nak);
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(nak);
  endtask

  // R11: slave must be released while the master's acknowledge is clocked
  task automatic recv_byte(output logic [7:0] d, input logic more);
    logic b;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      get_bit(b);
      d = {d[6:0], b};
    end
    m_sda = ~more; wq(Q); m_scl = 1'b1; wq(Q);
    check8("R11 release in master ack", {7'd0, sda_oe}, 8'd0);
    wq(Q); m_scl = 1'b0; wq(Q);
  endtask

  task automatic wr_byte(input logic [7:0] a, input logic [7:0] d);
    logic nak;
    bus_start;
    send_byte({SEL, 1'b0}, nak); check8("R2 control ack", {7'd0, nak}, 8'd0);
    send_byte(a, nak);           check8("R3 address ack", {7'd0, nak}, 8'd0);
    send_byte(d, nak);           check8("R4 data ack", {7'd0, nak}, 8'd0);
    bus_stop;
    model[a] = d;
    mptr = a + 8'd1;
  endtask

  task automatic set_ptr(input logic [7:0] a);
    logic nak;
    bus_start;
    send_byte({SEL, 1'b0}, nak); check8("R2 control ack", {7'd0, nak}, 8'd0);
    send_byte(a, nak);           check8("R3 address ack", {7'd0, nak}, 8'd0);
    bus_stop;
    mptr = a;
  endtask

  task automatic do_read(input logic rand_mode, input logic [7:0] a, input int n,
                         input string req);
    logic nak;
    logic [7:0] got;
    bus_start;
    if (rand_mode) begin
      send_byte({SEL, 1'b0}, nak); check8("R2 control ack", {7'd0, nak}, 8'd0);
      send_byte(a, nak);           check8("R6 address ack", {7'd0, nak}, 8'd0);
      mptr = a;
      bus_start;
    end
    send_byte({SEL, 1'b1}, nak);   check8("R2 read control ack", {7'd0, nak}, 8'd0);
    for (int i = 0; i < n; i++) begin
      recv_byte(got, i < n - 1);
      check8(req, got, model[mptr]);
      mptr = mptr + 8'd1;
    end
    check8("R7 released after nack", {7'd0, sda_oe}, 8'd0);
    bus_stop;
  endtask

  task automatic t_reset;
    wq(20);
    check8("R1 idle after reset", {7'd0, sda_oe}, 8'd0);
  endtask

  task automatic t_fill;
    wr_byte(8'h20, 8'hA1); wr_byte(8'h21, 8'hB2);
    wr_byte(8'h22, 8'hC3); wr_byte(8'h23, 8'hD4);
    wr_byte(8'h31, 8'h99); wr_byte(8'hFF, 8'h5A);
    wr_byte(8'h00, 8'h6B); wr_byte(8'h01, 8'h7C);
  endtask

  task automatic t_wrong_select;
    logic nak;
    logic [7:0] got;
    bus_start;
    send_byte({4'b1010, 3'd4, 1'b1}, nak);
    check8("R2 mismatch not acked", {7'd0, nak}, 8'd1);
    recv_byte(got, 1'b0);
    check8("R2 mismatch line stays high", got, 8'hFF);
    bus_stop;
    do_read(1'b0, 8'h00, 1, "R2 pointer kept after mismatch");
  endtask

  task automatic t_abort;
    logic nak;
    set_ptr(8'h20);
    // START inside the address byte
    bus_start;
    send_byte({SEL, 1'b0}, nak); check8("R10 control ack", {7'd0, nak}, 8'd0);
    for (int i = 7; i >= 4; i--) put_bit(8'h31 >> i);
    do_read(1'b0, 8'h00, 1, "R10 start mid address");
    // STOP inside the data byte
    bus_start;
    send_byte({SEL, 1'b0}, nak); check8("R10 control ack", {7'd0, nak}, 8'd0);
    send_byte(8'h22, nak);       check8("R10 address ack", {7'd0, nak}, 8'd0);
    mptr = 8'h22;
    put_bit(1'b0); put_bit(1'b0); put_bit(1'b0);
    bus_stop;
    do_read(1'b0, 8'h00, 1, "R10 stop mid data");
  endtask

  task automatic t_two_bytes;
    logic nak;
    bus_start;
    send_byte({SEL, 1'b0}, nak); check8("R12 control ack", {7'd0, nak}, 8'd0);
    send_byte(8'h30, nak);       check8("R12 address ack", {7'd0, nak}, 8'd0);
    send_byte(8'h11, nak);       check8("R4 first data ack", {7'd0, nak}, 8'd0);
    send_byte(8'h22, nak);       check8("R12 second data nacked", {7'd0, nak}, 8'd1);
    bus_stop;
    model[8'h30] = 8'h11;
    mptr = 8'h31;
    do_read(1'b0, 8'h00, 1, "R12 next byte unchanged");
    do_read(1'b1, 8'h30, 1, "R4 stored byte");
  endtask

  initial begin
    wq(5);
    rst = 1'b0;
    t_reset;
    t_fill;
    do_read(1'b1, 8'h21, 1, "R6 random read");
    do_read(1'b0, 8'h00, 1, "R5 current read after read");
    do_read(1'b0, 8'h00, 1, "R5 current read advances");
    do_read(1'b1, 8'h20, 4, "R7 sequential read");
    do_read(1'b1, 8'hFF, 3, "R8 wrap sequential");
    set_ptr(8'h22);
    do_read(1'b0, 8'h00, 1, "R3 address-only write");
    t_wrong_select;
    t_abort;
    t_two_bytes;
    n_cmp++;
    if (r9_viol != 0) begin
      n_bad++;
      $display("FAIL R9 drive changed with SCL high actual=%0d expected=0", r9_viol);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule